// File: doc/BRIEF.md
# Wave-Ordered Memory Request Buffer

This block collects the memory requests of one dynamic wave, which reach it in any order, and sends them to a memory port in program order. Each request has its own sequence number. It also has a link to the operation before it and a link to the operation after it. Either link may be unknown. A held request becomes issuable when the chain of these links shows that the operation before it has gone. When that link is unknown, the request becomes issuable instead when an issued operation names it as its successor. Placeholder operations take part in the chain, but they never reach the memory port.

A relaxed mode loosens the rule for loads. A load in this mode waits only for the most recent earlier store, whose sequence number it carries in a separate ripple field. Loads can therefore pass one another, while stores and placeholders keep following the link chain. One buffer serves one wave. A wave-done flag marks the moment the operation that carries the end marker has issued. A clear pulse empties the buffer for the next wave.

Top module: `wave_order_buf`

## Requirements
- R1: After reset, and in the cycle after `clear_i` has been high, `out_valid_o` and `wave_done_o` are 0 and `in_ready_o` is 1. A clear also forgets every held request and every issue record, so a request whose predecessor issued before the clear stays held afterwards.
- R2: A request whose predecessor field holds the terminal code (all ones except bit 0, which is 62 for 6-bit numbers) is issuable at once. When the output slot is empty, it appears on `out_valid_o` in the second cycle after the cycle in which the input handshake completed.
- R3: A request whose predecessor field holds a valid sequence number (0 to 61) is not issued before that operation has issued. Requests therefore leave in program order, whatever order they arrived in.
- R4: A request whose predecessor field holds the unknown code (all ones, 63) is issued only after an issued operation has named this request's sequence number in its successor field. A successor field may also be unknown.
- R5: A placeholder operation (op code 2) never appears on the output. Its issue is still recorded: it releases the request that follows it, and it completes the wave when it carries the end marker. Op code 0 is a load and op code 1 is a store.
- R6: When several held requests are issuable in the same cycle, the one with the lowest sequence number goes first, and at most one request issues per cycle.
- R7: With `relaxed_i` high, a load waits only until the store named in its ripple field has issued. A ripple value of 62 means no earlier store, and the load is then issuable at once. Stores and placeholders follow the link chain of R3 and R4.
- R8: While `out_valid_o` is high and `out_ready_i` is low, the output stays valid and its op, sequence, address and data hold still.
- R9: `wave_done_o` rises once the operation whose successor field holds the terminal code has been accepted at the output, or, for a placeholder, retired. It then stays high until a clear.
- R10: The buffer holds 16 requests. With 16 held, `in_ready_o` is 0, and it is also 0 while `clear_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clear_i | input | 1 | Empties the buffer and forgets the wave |
| relaxed_i | input | 1 | Loads order only against the stores named in their ripple fields |
| in_valid_i | input | 1 | Request offered |
| in_ready_o | output | 1 | Request can be taken |
| in_op_i | input | 2 | 0 load, 1 store, 2 placeholder |
| in_seq_i | input | 6 | Own sequence number |
| in_pred_i | input | 6 | Predecessor number, 62 start, 63 unknown |
| in_succ_i | input | 6 | Successor number, 62 end, 63 unknown |
| in_ripple_i | input | 6 | Latest earlier store, 62 none |
| in_addr_i | input | 32 | Request address |
| in_data_i | input | 32 | Store data |
| out_valid_o | output | 1 | Request presented to memory |
| out_ready_i | input | 1 | Memory takes the request |
| out_op_o | output | 2 | Op code of the presented request |
| out_seq_o | output | 6 | Sequence number of the presented request |
| out_addr_o | output | 32 | Address of the presented request |
| out_data_o | output | 32 | Data of the presented request |
| wave_done_o | output | 1 | End-marked operation has issued |

## Verification
A corrupt issue record, or a link resolved the wrong way, shows at the output as a sequence number out of program order. The error appears as early as the next handshake, two cycles after the offending request arrives. A lost record shows instead as a request that never leaves, and the stall is caught when the expected queue fails to drain. A slot that is never freed lowers `in_ready_o` before 16 requests are held. Any placeholder that leaks out appears at once as an unexpected output item.

// File: rtl/wob_pkg.sv
package wob_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_NOP   = 2'd2
  } op_e;
endpackage

// File: rtl/wob_slots.sv
module wob_slots
  import wob_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int SEQ_W  = 6,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clear_i,
  input  logic                          wr_en_i,
  input  op_e                           wr_op_i,
  input  logic [SEQ_W-1:0]              wr_seq_i,
  input  logic [SEQ_W-1:0]              wr_pred_i,
  input  logic [SEQ_W-1:0]              wr_succ_i,
  input  logic [SEQ_W-1:0]              wr_rip_i,
  input  logic [ADDR_W-1:0]             wr_addr_i,
  input  logic [DATA_W-1:0]             wr_data_i,
  input  logic                          free_en_i,
  input  logic [$clog2(DEPTH)-1:0]      free_idx_i,
  output logic                          full_o,
  output logic [DEPTH-1:0]              vld_o,
  output op_e  [DEPTH-1:0]              op_o,
  output logic [DEPTH-1:0][SEQ_W-1:0]   seq_o,
  output logic [DEPTH-1:0][SEQ_W-1:0]   pred_o,
  output logic [DEPTH-1:0][SEQ_W-1:0]   succ_o,
  output logic [DEPTH-1:0][SEQ_W-1:0]   rip_o,
  output logic [DEPTH-1:0][ADDR_W-1:0]  addr_o,
  output logic [DEPTH-1:0][DATA_W-1:0]  data_o
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DEPTH-1:0] vld_q, vld_d;
  logic [IDX_W-1:0] alloc_idx;

  // lowest free slot takes the next request
  always_comb begin
    alloc_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!vld_q[i]) alloc_idx = IDX_W'(i);
    end
  end

  assign full_o = &vld_q;
  assign vld_o  = vld_q;

  always_comb begin
    vld_d = vld_q;
    if (free_en_i) vld_d[free_idx_i] = 1'b0;
    if (wr_en_i)   vld_d[alloc_idx]  = 1'b1;
    if (clear_i)   vld_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  // payload storage, written with an explicit enable, no reset needed
  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      op_o[alloc_idx]   <= wr_op_i;
      seq_o[alloc_idx]  <= wr_seq_i;
      pred_o[alloc_idx] <= wr_pred_i;
      succ_o[alloc_idx] <= wr_succ_i;
      rip_o[alloc_idx]  <= wr_rip_i;
      addr_o[alloc_idx] <= wr_addr_i;
      data_o[alloc_idx] <= wr_data_i;
    end
  end

  // a write never lands while every slot is held
  assert_no_write_when_full_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |-> !full_o);

  // a slot being retired must be holding a request
  assert_free_held_slot_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    free_en_i |-> vld_q[free_idx_i]);
endmodule

// File: rtl/wob_track.sv
module wob_track #(
  parameter int SEQ_W = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear_i,
  input  logic                   mark_en_i,
  input  logic [SEQ_W-1:0]       mark_seq_i,
  input  logic [SEQ_W-1:0]       mark_succ_i,
  output logic [2**SEQ_W-1:0]    issued_o,
  output logic [2**SEQ_W-1:0]    named_o
);
  localparam int NSEQ = 2 ** SEQ_W;
  localparam logic [SEQ_W-1:0] SEQ_TERM = {{(SEQ_W-1){1'b1}}, 1'b0};

  logic [NSEQ-1:0] issued_q, issued_d;
  logic [NSEQ-1:0] named_q, named_d;

  always_comb begin
    issued_d = issued_q;
    named_d  = named_q;
    if (mark_en_i) begin
      issued_d[mark_seq_i] = 1'b1;
      // only a real sequence number can be named as a successor
      if (mark_succ_i < SEQ_TERM) named_d[mark_succ_i] = 1'b1;
    end
    if (clear_i) begin
      issued_d = '0;
      named_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issued_q <= '0;
      named_q  <= '0;
    end else begin
      issued_q <= issued_d;
      named_q  <= named_d;
    end
  end

  assign issued_o = issued_q;
  assign named_o  = named_q;

  // issue history only grows within a wave
  assert_issued_monotonic_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clear_i) |-> ((issued_q & $past(issued_q)) == $past(issued_q)));

  // a clear wipes the whole history
  assert_clear_forgets_R1 : assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (issued_q == '0) && (named_q == '0));
endmodule

// File: rtl/wob_elig.sv
module wob_elig
  import wob_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int SEQ_W = 6
) (
  input  logic                         relaxed_i,
  input  logic [DEPTH-1:0]             vld_i,
  input  op_e  [DEPTH-1:0]             op_i,
  input  logic [DEPTH-1:0][SEQ_W-1:0]  seq_i,
  input  logic [DEPTH-1:0][SEQ_W-1:0]  pred_i,
  input  logic [DEPTH-1:0][SEQ_W-1:0]  rip_i,
  input  logic [2**SEQ_W-1:0]          issued_i,
  input  logic [2**SEQ_W-1:0]          named_i,
  output logic [DEPTH-1:0]             elig_o
);
  localparam logic [SEQ_W-1:0] SEQ_UNK  = {SEQ_W{1'b1}};
  localparam logic [SEQ_W-1:0] SEQ_TERM = {{(SEQ_W-1){1'b1}}, 1'b0};

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic chain_ok;
    logic rip_ok;
    logic use_rip;

    // link chain: start marker, known predecessor, or named as a successor
    always_comb begin
      if (pred_i[g] == SEQ_TERM)     chain_ok = 1'b1;
      else if (pred_i[g] == SEQ_UNK) chain_ok = named_i[seq_i[g]];
      else                           chain_ok = issued_i[pred_i[g]];
    end

    // ripple: waits on the latest earlier store only
    always_comb begin
      if (rip_i[g] == SEQ_TERM)     rip_ok = 1'b1;
      else if (rip_i[g] == SEQ_UNK) rip_ok = chain_ok;
      else                          rip_ok = issued_i[rip_i[g]];
    end

    assign use_rip   = relaxed_i && (op_i[g] == OP_LOAD);
    assign elig_o[g] = vld_i[g] && (use_rip ? rip_ok : chain_ok);
  end
endmodule

// File: rtl/wob_pick.sv
module wob_pick #(
  parameter int DEPTH = 16,
  parameter int SEQ_W = 6
) (
  input  logic [DEPTH-1:0]             elig_i,
  input  logic [DEPTH-1:0][SEQ_W-1:0]  seq_i,
  output logic                         any_o,
  output logic [$clog2(DEPTH)-1:0]     idx_o
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [SEQ_W-1:0] best_seq;

  // oldest issuable request wins
  always_comb begin
    any_o    = 1'b0;
    idx_o    = '0;
    best_seq = '1;
    for (int i = 0; i < DEPTH; i++) begin
      if (elig_i[i] && (!any_o || (seq_i[i] < best_seq))) begin
        any_o    = 1'b1;
        idx_o    = IDX_W'(i);
        best_seq = seq_i[i];
      end
    end
  end
endmodule

// File: rtl/wave_order_buf.sv
module wave_order_buf
  import wob_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int SEQ_W  = 6,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              relaxed_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [1:0]        in_op_i,
  input  logic [SEQ_W-1:0]  in_seq_i,
  input  logic [SEQ_W-1:0]  in_pred_i,
  input  logic [SEQ_W-1:0]  in_succ_i,
  input  logic [SEQ_W-1:0]  in_ripple_i,
  input  logic [ADDR_W-1:0] in_addr_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [1:0]        out_op_o,
  output logic [SEQ_W-1:0]  out_seq_o,
  output logic [ADDR_W-1:0] out_addr_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              wave_done_o
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int NSEQ  = 2 ** SEQ_W;
  localparam logic [SEQ_W-1:0] SEQ_UNK  = {SEQ_W{1'b1}};
  localparam logic [SEQ_W-1:0] SEQ_TERM = {{(SEQ_W-1){1'b1}}, 1'b0};

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_n_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe[1];

  // slot array
  logic                          full;
  logic                          wr_en;
  logic [DEPTH-1:0]              s_vld;
  op_e  [DEPTH-1:0]              s_op;
  logic [DEPTH-1:0][SEQ_W-1:0]   s_seq, s_pred, s_succ, s_rip;
  logic [DEPTH-1:0][ADDR_W-1:0]  s_addr;
  logic [DEPTH-1:0][DATA_W-1:0]  s_data;
  logic [DEPTH-1:0]              elig;
  logic [NSEQ-1:0]               issued_vec, named_vec;
  logic                          pick_any;
  logic [IDX_W-1:0]              pick_idx;
  logic                          take;

  assign in_ready_o = !full && !clear_i;
  assign wr_en      = in_valid_i && in_ready_o;

  wob_slots #(
    .DEPTH(DEPTH), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_slots (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .clear_i    (clear_i),
    .wr_en_i    (wr_en),
    .wr_op_i    (op_e'(in_op_i)),
    .wr_seq_i   (in_seq_i),
    .wr_pred_i  (in_pred_i),
    .wr_succ_i  (in_succ_i),
    .wr_rip_i   (in_ripple_i),
    .wr_addr_i  (in_addr_i),
    .wr_data_i  (in_data_i),
    .free_en_i  (take),
    .free_idx_i (pick_idx),
    .full_o     (full),
    .vld_o      (s_vld),
    .op_o       (s_op),
    .seq_o      (s_seq),
    .pred_o     (s_pred),
    .succ_o     (s_succ),
    .rip_o      (s_rip),
    .addr_o     (s_addr),
    .data_o     (s_data)
  );

  wob_elig #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_elig (
    .relaxed_i (relaxed_i),
    .vld_i     (s_vld),
    .op_i      (s_op),
    .seq_i     (s_seq),
    .pred_i    (s_pred),
    .rip_i     (s_rip),
    .issued_i  (issued_vec),
    .named_i   (named_vec),
    .elig_o    (elig)
  );

  wob_pick #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_pick (
    .elig_i (elig),
    .seq_i  (s_seq),
    .any_o  (pick_any),
    .idx_o  (pick_idx)
  );

  // fields of the chosen slot
  op_e              pick_op;
  logic [SEQ_W-1:0] pick_seq, pick_pred, pick_succ;
  assign pick_op   = s_op[pick_idx];
  assign pick_seq  = s_seq[pick_idx];
  assign pick_pred = s_pred[pick_idx];
  assign pick_succ = s_succ[pick_idx];

  // output register
  logic              out_valid_q, out_valid_d;
  op_e               out_op_q;
  logic [SEQ_W-1:0]  out_seq_q, out_succ_q;
  logic [ADDR_W-1:0] out_addr_q;
  logic [DATA_W-1:0] out_data_q;
  logic              out_load;
  logic              out_accept;
  logic              pick_nop;
  logic              done_q, done_d;

  assign pick_nop   = (pick_op == OP_NOP);
  assign out_accept = out_valid_q && out_ready_i;
  // a placeholder retires without the output slot; others need it free
  assign take       = pick_any && !clear_i && (pick_nop || !out_valid_q || out_ready_i);
  assign out_load   = take && !pick_nop;

  wob_track #(.SEQ_W(SEQ_W)) u_track (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .clear_i     (clear_i),
    .mark_en_i   (take),
    .mark_seq_i  (pick_seq),
    .mark_succ_i (pick_succ),
    .issued_o    (issued_vec),
    .named_o     (named_vec)
  );

  always_comb begin
    out_valid_d = out_valid_q;
    if (out_accept) out_valid_d = 1'b0;
    if (out_load)   out_valid_d = 1'b1;
    if (clear_i)    out_valid_d = 1'b0;
  end

  always_comb begin
    done_d = done_q;
    if (out_accept && (out_succ_q == SEQ_TERM))     done_d = 1'b1;
    if (take && pick_nop && (pick_succ == SEQ_TERM)) done_d = 1'b1;
    if (clear_i)                                     done_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      out_valid_q <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      out_valid_q <= out_valid_d;
      done_q      <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (out_load) begin
      out_op_q   <= pick_op;
      out_seq_q  <= pick_seq;
      out_succ_q <= pick_succ;
      out_addr_q <= s_addr[pick_idx];
      out_data_q <= s_data[pick_idx];
    end
  end

  assign out_valid_o = out_valid_q;
  assign out_op_o    = out_op_q;
  assign out_seq_o   = out_seq_q;
  assign out_addr_o  = out_addr_q;
  assign out_data_o  = out_data_q;
  assign wave_done_o = done_q;

  // held output is frozen until taken
  assert_out_hold_R8 : assert property (@(posedge clk) disable iff (!rst_n_sync)
    out_valid_o && !out_ready_i && !clear_i |=>
      out_valid_o && $stable(out_seq_o) && $stable(out_op_o)
      && $stable(out_addr_o) && $stable(out_data_o));

  // placeholders never reach memory
  assert_no_nop_out_R5 : assert property (@(posedge clk) disable iff (!rst_n_sync)
    out_valid_o |-> (out_op_o != 2'd2));

  // a known predecessor has issued before its follower goes
  assert_pred_issued_R3 : assert property (@(posedge clk) disable iff (!rst_n_sync)
    take && (pick_pred < SEQ_TERM) && !(relaxed_i && pick_op == OP_LOAD)
      |-> issued_vec[pick_pred]);

  // an unknown predecessor is bridged only by an issued naming operation
  assert_unknown_link_R4 : assert property (@(posedge clk) disable iff (!rst_n_sync)
    take && (pick_pred == SEQ_UNK) && !(relaxed_i && pick_op == OP_LOAD)
      |-> named_vec[pick_seq]);

  // the chosen slot is one the eligibility logic released
  assert_pick_eligible_R6 : assert property (@(posedge clk) disable iff (!rst_n_sync)
    pick_any |-> elig[pick_idx]);

  // done stays until a clear
  assert_done_sticky_R9 : assert property (@(posedge clk) disable iff (!rst_n_sync)
    wave_done_o && !clear_i |=> wave_done_o);
endmodule

// File: tb/test_wave_order_buf.sv
module test_wave_order_buf;
  localparam int SEQ_W = 6;
  localparam int TERM  = 62;
  localparam int UNK   = 63;
  localparam int LD = 0, ST = 1, NP = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        clear;
  logic        relaxed;
  logic        in_valid;
  logic        in_ready;
  logic [1:0]  in_op;
  logic [5:0]  in_seq, in_pred, in_succ, in_rip;
  logic [31:0] in_addr, in_data;
  logic        out_valid;
  logic        out_ready;
  logic [1:0]  out_op;
  logic [5:0]  out_seq;
  logic [31:0] out_addr, out_data;
  logic        wave_done;

  always #5 clk = ~clk;

  wave_order_buf i_wave_order_buf (
    .clk(clk), .rst_n(rst_n), .clear_i(clear), .relaxed_i(relaxed),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_op_i(in_op),
    .in_seq_i(in_seq), .in_pred_i(in_pred), .in_succ_i(in_succ),
    .in_ripple_i(in_rip), .in_addr_i(in_addr), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_op_o(out_op),
    .out_seq_o(out_seq), .out_addr_o(out_addr), .out_data_o(out_data),
    .wave_done_o(wave_done)
  );

  typedef struct {
    int    op;
    int    seq;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;

  function automatic logic [31:0] addr_of(int s); return 32'h0000_1000 + 32'(s * 4); endfunction
  function automatic logic [31:0] data_of(int s); return 32'hA500_0000 + 32'(s); endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic expect_item(input int op, input int seq, input string req);
    exp_t e;
    e.op = op; e.seq = seq; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic send(input int op, input int seq, input int pred, input int succ, input int rip);
    @(posedge clk); #1;
    in_valid = 1'b1;
    in_op = 2'(op); in_seq = 6'(seq); in_pred = 6'(pred); in_succ = 6'(succ); in_rip = 6'(rip);
    in_addr = addr_of(seq); in_data = data_of(seq);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic do_clear();
    @(posedge clk); #1 clear = 1'b1;
    @(posedge clk); #1 clear = 1'b0;
    @(negedge clk);
    chk("R1", "out_valid after clear", out_valid, 0);
    chk("R1", "wave_done after clear", wave_done, 0);
    chk("R1", "in_ready after clear", in_ready, 1);
  endtask

  task automatic drain(input string req);
    for (int n = 0; n < 300 && exp_q.size() != 0; n++) @(negedge clk);
    chk(req, "items left undelivered", exp_q.size(), 0);
    repeat (3) @(negedge clk);
  endtask

  // monitor: scoreboard pop plus hold check
  logic       hold_pend = 1'b0;
  logic [1:0] h_op;
  logic [5:0] h_seq;
  logic [31:0] h_addr, h_data;

  always @(negedge clk) begin
    if (rst_n && !clear) begin
      if (hold_pend) begin
        chk("R8", "valid held", out_valid, 1);
        chk("R8", "held seq/op/addr/data", {out_op, out_seq, out_addr, out_data},
            {h_op, h_seq, h_addr, h_data});
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk("R5", "unexpected output seq", out_seq, 0);
          errors += (out_seq == 0) ? 1 : 0;
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(e.req, "output seq order", out_seq, e.seq);
          chk(e.req, "output op", out_op, e.op);
          chk(e.req, "output addr/data", {out_addr, out_data}, {addr_of(e.seq), data_of(e.seq)});
        end
      end
      hold_pend = out_valid && !out_ready;
      h_op = out_op; h_seq = out_seq; h_addr = out_addr; h_data = out_data;
    end else begin
      hold_pend = 1'b0;
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run did not end actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; clear = 1'b0; relaxed = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    in_op = '0; in_seq = '0; in_pred = '0; in_succ = '0; in_rip = '0; in_addr = '0; in_data = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "out_valid after reset", out_valid, 0);
    chk("R1", "wave_done after reset", wave_done, 0);
    chk("R1", "in_ready after reset", in_ready, 1);

    // R2: start-marked request, exact latency, then held output
    #1 out_ready = 1'b0;
    expect_item(LD, 0, "R2");
    send(LD, 0, TERM, TERM, TERM);
    @(negedge clk); chk("R2", "out_valid one cycle after accept", out_valid, 0);
    @(negedge clk); chk("R2", "out_valid two cycles after accept", out_valid, 1);
    chk("R2", "presented seq", out_seq, 0);
    repeat (3) @(negedge clk);
    @(posedge clk); #1 out_ready = 1'b1;
    drain("R2");
    chk("R9", "done after end op accepted", wave_done, 1);

    // R3: reverse arrival, program-order release
    do_clear();
    expect_item(ST, 0, "R3"); expect_item(LD, 1, "R3");
    expect_item(ST, 2, "R3"); expect_item(LD, 3, "R3");
    send(LD, 3, 2, TERM, TERM);
    send(ST, 2, 1, 3, TERM);
    send(LD, 1, 0, 2, TERM);
    repeat (4) @(negedge clk);
    chk("R3", "no release before head arrives", out_valid, 0);
    chk("R9", "not done mid wave", wave_done, 0);
    send(ST, 0, TERM, 1, TERM);
    drain("R3");
    chk("R9", "done after wave", wave_done, 1);

    // R1: clear forgets issue history
    do_clear();
    send(LD, 1, 0, TERM, TERM);
    repeat (5) @(negedge clk);
    chk("R1", "old predecessor forgotten", out_valid, 0);
    chk("R1", "done stays low", wave_done, 0);

    // R4: unknown links
    do_clear();
    expect_item(LD, 0, "R4"); expect_item(ST, 3, "R4"); expect_item(LD, 5, "R4");
    send(LD, 5, UNK, TERM, TERM);
    send(ST, 3, 0, 5, TERM);
    repeat (4) @(negedge clk);
    chk("R4", "unlinked requests held", out_valid, 0);
    send(LD, 0, TERM, UNK, TERM);
    drain("R4");
    chk("R9", "done after unknown chain", wave_done, 1);

    // R5: placeholder in the middle
    do_clear();
    expect_item(LD, 0, "R5"); expect_item(ST, 2, "R5");
    send(NP, 1, 0, 2, TERM);
    send(ST, 2, 1, TERM, TERM);
    send(LD, 0, TERM, 1, TERM);
    drain("R5");
    chk("R5", "nothing left on output", out_valid, 0);
    chk("R5", "done after chain through placeholder", wave_done, 1);

    // R5: placeholder carrying the end marker
    do_clear();
    expect_item(LD, 0, "R5");
    send(NP, 1, 0, TERM, TERM);
    send(LD, 0, TERM, 1, TERM);
    drain("R5");
    chk("R5", "done via end placeholder", wave_done, 1);

    // R7: relaxed loads wait on their ripple store only
    relaxed = 1'b1;
    do_clear();
    expect_item(ST, 0, "R7"); expect_item(LD, 2, "R7");
    send(LD, 2, 1, 3, 0);
    repeat (4) @(negedge clk);
    chk("R7", "load waits for its store", out_valid, 0);
    send(ST, 0, TERM, 1, TERM);
    drain("R7");
    chk("R7", "wave not done yet", wave_done, 0);
    expect_item(LD, 1, "R7"); expect_item(ST, 3, "R7");
    send(LD, 1, 0, 2, 0);
    send(ST, 3, 2, TERM, 0);
    drain("R7");
    chk("R9", "relaxed wave done", wave_done, 1);

    // R6: several issuable at once, lowest sequence first
    do_clear();
    @(posedge clk); #1 out_ready = 1'b0;
    expect_item(LD, 0, "R6"); expect_item(LD, 1, "R6");
    expect_item(LD, 2, "R6"); expect_item(LD, 3, "R6");
    send(LD, 0, TERM, 1, TERM);
    send(LD, 3, 2, TERM, TERM);
    send(LD, 2, 1, 3, TERM);
    send(LD, 1, 0, 2, TERM);
    repeat (2) @(negedge clk);
    @(posedge clk); #1 out_ready = 1'b1;
    drain("R6");
    chk("R9", "done after priority wave", wave_done, 1);

    // R10: capacity
    relaxed = 1'b0;
    do_clear();
    for (int i = 1; i <= 16; i++) begin
      send(LD, i, i - 1, i + 1, TERM);
      if (i == 15) begin
        @(negedge clk);
        chk("R10", "ready with one slot free", in_ready, 1);
      end
    end
    @(negedge clk);
    chk("R10", "not ready when full", in_ready, 0);
    chk("R10", "nothing issuable", out_valid, 0);
    do_clear();

    finish_run();
  end
endmodule